// File: doc/BRIEF.md
# Serial Link Request Transmitter

This block sits on the link-layer side of a PHY-link interface. It takes one command at a time from a local valid/ready port and turns it into a variable-length serial frame on a single request line, sending one bit per clock, most significant bit first. When the frame is done, the line returns low.

There are four kinds of command: a bus request (access class and speed code), a register read (address), a register write (address and data byte) and an acceleration control (enable flag). Each frame starts with a 1, which is followed by a 3-bit type code and the payload. Every frame except the short bus form ends with a 0 stop bit. The transmitter allows only one bus request to be outstanding at a time. That request is released by a won strobe, a lost strobe or a bus reset strobe. Register and acceleration commands can still pass while a bus request is outstanding.

Back-pressure rules are as follows. `cmd_ready` is low for the whole time a frame is on the line. It is also low whenever the offered command is a bus request and another bus request is outstanding. `cmd_ready` depends on `cmd_kind`, but it never depends on `cmd_valid`. A command transfers on a rising edge where `cmd_valid` and `cmd_ready` are both high. A command that is held off stays offered and is not dropped.

Top module: `link_req_tx`

## Requirements
- R1: After reset, `req_line` is low and `cmd_ready` is high for a non-bus command.
- R2: The line carries frame bit 0 first. Bit 0 is always 1. Bits 1 to 3 hold the type code: bus classes 000 immediate, 001 isochronous, 010 priority, 011 fair (class = `{0, cmd_bus_type}`), then 100 read, 101 write and 110 acceleration. Code 111 is never sent.
- R3: When `cmd_speed[0]` is 1, a bus request is 8 bits long: start, type, `cmd_speed[2:0]` in bits 4 to 6 (MSB first), then a 0 stop bit. Speed codes that are not valid are sent unchanged.
- R4: When `cmd_speed[0]` is 0, a bus request is 7 bits long and has no separate stop bit.
- R5: A register read is 9 bits long: start, 100, address in bits 4 to 7 (MSB first), then stop 0.
- R6: A register write is 17 bits long: start, 101, address in bits 4 to 7, data in bits 8 to 15 (MSB first), then stop 0.
- R7: An acceleration control frame is 6 bits long: start, 110, the enable flag (1 = enable), then stop 0.
- R8: The first bit goes out in the cycle after acceptance. `cmd_ready` stays low for exactly the frame length in cycles and rises in the cycle after the final bit.
- R9: Once a bus request has been accepted, a further bus request is held off with `cmd_ready` low and is not discarded. It is accepted and sent after a `bus_won` or `bus_lost` strobe.
- R10: A `bus_reset` strobe clears the outstanding bus request in the same way.
- R11: Read, write and acceleration commands are accepted and sent while a bus request is outstanding.
- R12: After every frame, the line is low for at least one cycle before the next start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_kind | input | 2 | 0 bus, 1 read, 2 write, 3 acceleration |
| cmd_bus_type | input | 2 | Bus class: 0 immediate, 1 isochronous, 2 priority, 3 fair |
| cmd_speed | input | SPEED_W (3) | Speed code for bus requests |
| cmd_addr | input | ADDR_W (4) | Register address |
| cmd_data | input | DATA_W (8) | Register write data |
| cmd_accel_en | input | 1 | Acceleration enable flag |
| bus_won | input | 1 | Arbitration won strobe |
| bus_lost | input | 1 | Arbitration lost strobe |
| bus_reset | input | 1 | Bus reset strobe |
| req_line | output | 1 | Serial request line, idles low |

## Verification
The bench builds the block with its default widths: a 4-bit address, an 8-bit data byte and a 3-bit speed code. With these widths the write frame is 17 bits, which is the longest shift, and both the 7-bit and the 8-bit bus forms are reachable by choosing the low speed bit. The speed codes used include codes that are not valid, to show they are passed through unchanged. Held-off bus requests are released by each of the three clearing strobes in turn.

// File: rtl/lreq_pkg.sv
package lreq_pkg;
  typedef enum logic [1:0] {
    CMD_BUS = 2'd0,
    CMD_RD  = 2'd1,
    CMD_WR  = 2'd2,
    CMD_ACC = 2'd3
  } cmd_kind_e;

  localparam int TYPE_W = 3;
  localparam logic [TYPE_W-1:0] TY_RD  = 3'b100;
  localparam logic [TYPE_W-1:0] TY_WR  = 3'b101;
  localparam logic [TYPE_W-1:0] TY_ACC = 3'b110;
endpackage

// File: rtl/lreq_frame_build.sv
module lreq_frame_build
  import lreq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int SPEED_W = 3,
  parameter int FRAME_W = 17,
  parameter int LEN_W   = 5
) (
  input  cmd_kind_e           kind,
  input  logic [1:0]          bus_type,
  input  logic [SPEED_W-1:0]  speed,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   data,
  input  logic                accel_en,
  output logic [FRAME_W-1:0]  frame,
  output logic [LEN_W-1:0]    len
);
  localparam int LEN_BUS = 2 + TYPE_W + SPEED_W;
  localparam int LEN_RD  = 2 + TYPE_W + ADDR_W;
  localparam int LEN_WR  = LEN_RD + DATA_W;
  localparam int LEN_ACC = 3 + TYPE_W;

  logic [FRAME_W-1:0] raw;
  int unsigned        shamt;

  // Each frame is built right-aligned, then moved to the top of the vector
  always_comb begin
    raw   = '0;
    shamt = 0;
    len   = '0;
    unique case (kind)
      CMD_BUS: begin
        raw   = FRAME_W'({1'b1, 1'b0, bus_type, speed, 1'b0});
        shamt = FRAME_W - LEN_BUS;
        // short form: the last speed bit is 0 and serves as the stop bit
        len   = speed[0] ? LEN_W'(LEN_BUS) : LEN_W'(LEN_BUS - 1);
      end
      CMD_RD: begin
        raw   = FRAME_W'({1'b1, TY_RD, addr, 1'b0});
        shamt = FRAME_W - LEN_RD;
        len   = LEN_W'(LEN_RD);
      end
      CMD_WR: begin
        raw   = FRAME_W'({1'b1, TY_WR, addr, data, 1'b0});
        shamt = FRAME_W - LEN_WR;
        len   = LEN_W'(LEN_WR);
      end
      CMD_ACC: begin
        raw   = FRAME_W'({1'b1, TY_ACC, accel_en, 1'b0});
        shamt = FRAME_W - LEN_ACC;
        len   = LEN_W'(LEN_ACC);
      end
      default: begin
        raw   = '0;
        shamt = 0;
        len   = '0;
      end
    endcase
    frame = raw << shamt;
  end
endmodule

// File: rtl/lreq_shifter.sv
module lreq_shifter #(
  parameter int FRAME_W = 17,
  parameter int LEN_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] load_frame,
  input  logic [LEN_W-1:0]   load_len,
  output logic               busy,
  output logic               line
);
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg <= '0;
      left  <= '0;
    end else if (load) begin
      shreg <= load_frame;
      left  <= load_len;
    end else if (left != '0) begin
      shreg <= shreg << 1;
      left  <= left - 1'b1;
    end
  end

  assign busy = (left != '0);
  assign line = busy & shreg[FRAME_W-1];

  AST_START_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> line); // R2
  AST_LAST_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && left == LEN_W'(1)) |-> !line); // R3
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R8
  AST_LEN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    left <= LEN_W'(FRAME_W)); // R8
endmodule

// File: rtl/lreq_bus_lock.sv
module lreq_bus_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic won,
  input  logic lost,
  input  logic bus_reset,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n)                       pending <= 1'b0;
    else if (take)                    pending <= 1'b1;
    else if (won || lost || bus_reset) pending <= 1'b0;
  end

  AST_ONE_BUS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !pending); // R9
  AST_OUTCOME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((won || lost) && !take) |=> !pending); // R9
  AST_BUS_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset && !take) |=> !pending); // R10
endmodule

// File: rtl/link_req_tx.sv
module link_req_tx
  import lreq_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int SPEED_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_kind,
  input  logic [1:0]         cmd_bus_type,
  input  logic [SPEED_W-1:0] cmd_speed,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [DATA_W-1:0]  cmd_data,
  input  logic               cmd_accel_en,
  input  logic               bus_won,
  input  logic               bus_lost,
  input  logic               bus_reset,
  output logic               req_line
);
  localparam int LEN_BUS = 2 + TYPE_W + SPEED_W;
  localparam int LEN_WR  = 2 + TYPE_W + ADDR_W + DATA_W;
  localparam int FRAME_W = (LEN_WR > LEN_BUS) ? LEN_WR : LEN_BUS;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  cmd_kind_e          kind;
  logic               is_bus, busy, pending, accept;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;

  assign kind      = cmd_kind_e'(cmd_kind);
  assign is_bus    = (kind == CMD_BUS);
  assign cmd_ready = !busy && !(is_bus && pending);
  assign accept    = cmd_valid && cmd_ready;

  lreq_frame_build #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPEED_W(SPEED_W),
    .FRAME_W(FRAME_W), .LEN_W(LEN_W)
  ) u_build (
    .kind(kind), .bus_type(cmd_bus_type), .speed(cmd_speed),
    .addr(cmd_addr), .data(cmd_data), .accel_en(cmd_accel_en),
    .frame(frame), .len(len)
  );

  lreq_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .load_frame(frame), .load_len(len),
    .busy(busy), .line(req_line)
  );

  lreq_bus_lock u_lock (
    .clk(clk), .rst_n(rst_n), .take(accept && is_bus),
    .won(bus_won), .lost(bus_lost), .bus_reset(bus_reset),
    .pending(pending)
  );

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !cmd_ready); // R8
  AST_NONBUS_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_bus && !busy) |-> cmd_ready); // R11
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(accept)) |-> !req_line); // R1
endmodule

// File: tb/link_req_tx_test.sv
module link_req_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int SPEED_W = 3;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_kind = 2'd3;
  logic [1:0] cmd_bus_type = '0;
  logic [SPEED_W-1:0] cmd_speed = '0;
  logic [ADDR_W-1:0] cmd_addr = '0;
  logic [DATA_W-1:0] cmd_data = '0;
  logic cmd_accel_en = 1'b0;
  logic bus_won = 1'b0, bus_lost = 1'b0, bus_reset = 1'b0;
  logic req_line;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_req_tx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SPEED_W(SPEED_W)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_bus_type(cmd_bus_type), .cmd_speed(cmd_speed),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_accel_en(cmd_accel_en),
    .bus_won(bus_won), .bus_lost(bus_lost), .bus_reset(bus_reset),
    .req_line(req_line)
  );

  typedef struct {
    int          len;
    logic [31:0] b;   // b[i] is frame bit i
    string       tag;
  } frm_t;

  frm_t exp_q[$];
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void put(ref frm_t f, input int pos, input int w, input logic [31:0] v);
    for (int k = 0; k < w; k++) f.b[pos+k] = v[w-1-k];
  endfunction

  function automatic frm_t expect_frame(input logic [1:0] kind, input logic [1:0] bt,
      input logic [2:0] spd, input logic [3:0] a, input logic [7:0] d, input logic en);
    frm_t f;
    f.b = '0;
    f.b[0] = 1'b1;
    case (kind)
      2'd0: begin put(f, 1, 3, {29'd0, 1'b0, bt}); put(f, 4, 3, {29'd0, spd});
                  f.len = spd[0] ? 8 : 7; f.tag = spd[0] ? "R3" : "R4"; end
      2'd1: begin put(f, 1, 3, 32'b100); put(f, 4, 4, {28'd0, a}); f.len = 9; f.tag = "R5"; end
      2'd2: begin put(f, 1, 3, 32'b101); put(f, 4, 4, {28'd0, a}); put(f, 8, 8, {24'd0, d});
                  f.len = 17; f.tag = "R6"; end
      default: begin put(f, 1, 3, 32'b110); f.b[4] = en; f.len = 6; f.tag = "R7"; end
    endcase
    return f;
  endfunction

  task automatic set_cmd(input logic [1:0] kind, input logic [1:0] bt,
      input logic [2:0] spd, input logic [3:0] a, input logic [7:0] d, input logic en);
    cmd_kind = kind; cmd_bus_type = bt; cmd_speed = spd;
    cmd_addr = a; cmd_data = d; cmd_accel_en = en;
  endtask

  // driver: offer, wait for ready, push expected frame, release
  task automatic send(input logic [1:0] kind, input logic [1:0] bt,
      input logic [2:0] spd, input logic [3:0] a, input logic [7:0] d, input logic en);
    @(negedge clk);
    set_cmd(kind, bt, spd, a, d, en);
    cmd_valid = 1'b1;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    exp_q.push_back(expect_frame(kind, bt, spd, a, d, en));
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_kind = 2'd3;
  endtask

  // offer a bus request while one is outstanding; release with a strobe (0 won, 1 lost, 2 reset)
  task automatic send_held(input logic [1:0] bt, input logic [2:0] spd, input int strobe, string tag);
    int held = 0;
    @(negedge clk);
    set_cmd(2'd0, bt, spd, 4'd0, 8'd0, 1'b0);
    cmd_valid = 1'b1;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (!cmd_ready) held++;
      @(negedge clk);
    end
    check(held == 20, tag, "bus request held off while outstanding", held, 20);
    case (strobe)
      0: bus_won = 1'b1;
      1: bus_lost = 1'b1;
      default: bus_reset = 1'b1;
    endcase
    @(negedge clk);
    bus_won = 1'b0; bus_lost = 1'b0; bus_reset = 1'b0;
    #1;
    check(cmd_ready == 1'b1, tag, "ready after clearing strobe", cmd_ready, 1);
    exp_q.push_back(expect_frame(2'd0, bt, spd, 4'd0, 8'd0, 1'b0));
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_kind = 2'd3;
  endtask

  task automatic pulse_won();
    @(negedge clk); bus_won = 1'b1;
    @(negedge clk); bus_won = 1'b0;
  endtask

  task automatic pulse_lost();
    @(negedge clk); bus_lost = 1'b1;
    @(negedge clk); bus_lost = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((exp_q.size() != 0 || req_line) && n < 200) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  // monitor: picks frames off the line and compares with the scoreboard
  initial begin : monitor
    frm_t cur;
    logic [31:0] got;
    int idx = 0;
    bit in_frame = 0;
    bit after = 0;
    bit rdy_bad = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (after) begin
          after = 0;
          check(req_line == 1'b0, "R12", "line low after frame", req_line, 0);
        end else if (!in_frame && req_line) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R2", "unexpected frame start", 1, 0);
          end else begin
            cur = exp_q.pop_front();
            idx = 0; got = '0; in_frame = 1; rdy_bad = 0;
          end
        end
        if (in_frame) begin
          got[idx] = req_line;
          if (cmd_ready) rdy_bad = 1;
          idx++;
          if (idx == cur.len) begin
            check(got == cur.b, cur.tag, "frame bits (R2 order)", got, cur.b);
            check(!rdy_bad, "R8", "ready low during frame", rdy_bad, 0);
            in_frame = 0;
            after = 1;
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int n;
    repeat (4) @(negedge clk);
    #1;
    check(req_line == 1'b0, "R1", "line low in reset", req_line, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(req_line == 1'b0, "R1", "line low after reset", req_line, 0);
    check(cmd_ready == 1'b1, "R1", "ready after reset", cmd_ready, 1);

    // bus requests, long and short forms, with invalid codes passed through
    send(2'd0, 2'd1, 3'b001, 4'd0, 8'd0, 1'b0);   // R3 iso, 8 bits
    drain(); pulse_won();
    send(2'd0, 2'd3, 3'b100, 4'd0, 8'd0, 1'b0);   // R4 fair S400, 7 bits
    drain(); pulse_lost();
    send(2'd0, 2'd2, 3'b000, 4'd0, 8'd0, 1'b0);   // R4 priority S100
    drain(); pulse_won();
    send(2'd0, 2'd0, 3'b111, 4'd0, 8'd0, 1'b0);   // R3 immediate invalid speed
    drain(); pulse_won();

    // register and acceleration frames, back to back (R12)
    send(2'd1, 2'd0, 3'd0, 4'hA, 8'h00, 1'b0);    // R5
    send(2'd2, 2'd0, 3'd0, 4'h5, 8'hA5, 1'b0);    // R6
    send(2'd2, 2'd0, 3'd0, 4'hF, 8'h3C, 1'b0);    // R6
    send(2'd3, 2'd0, 3'd0, 4'h0, 8'h00, 1'b1);    // R7
    send(2'd3, 2'd0, 3'd0, 4'h0, 8'h00, 1'b0);    // R7
    drain();

    // R8: ready low for exactly the frame length
    send(2'd3, 2'd0, 3'd0, 4'h0, 8'h00, 1'b1);
    #1;
    n = 0;
    while (!cmd_ready && n < 40) begin n++; @(negedge clk); #1; end
    check(n == 6, "R8", "ready low cycles for 6-bit frame", n, 6);
    drain();

    // R11: non-bus commands pass while a bus request is outstanding
    send(2'd0, 2'd0, 3'b010, 4'd0, 8'd0, 1'b0);
    send(2'd1, 2'd0, 3'd0, 4'h3, 8'h00, 1'b0);    // R11
    send(2'd2, 2'd0, 3'd0, 4'h9, 8'h81, 1'b0);    // R11
    send(2'd3, 2'd0, 3'd0, 4'h0, 8'h00, 1'b1);    // R11
    drain();

    // R9: held bus requests released by lost and by won
    send_held(2'd3, 3'b111, 1, "R9");
    drain();
    send_held(2'd1, 3'b010, 0, "R9");
    drain();
    // R10: released by bus reset
    send_held(2'd2, 3'b100, 2, "R10");
    drain();
    pulse_won();

    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R9", "all accepted frames sent", exp_q.size(), 0);
    check(req_line == 1'b0, "R1", "line idle at end", req_line, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule